// File: doc/BRIEF.md
# Dual-Channel Transmit FIFO Controller

This block holds outgoing frames for a host in two independent byte queues, one per transmit channel, and hands them to a byte-wide streaming sink. The host loads a queue through one shared 32-bit push register. A channel-select register decides which queue the push lands in. The host programs a per-channel byte count, then writes a per-channel start register. The block sends the bytes over a valid/ready interface that marks the final byte, empties the channel and flags completion in an interrupt status register.

The status bits are cleared by writing ones. They are masked by an enable register and ORed onto a single interrupt line. Both channels share one output stream, and a tag output tells the sink which channel is sending. A start on one channel while the other is sending is held and served once the output is free. A reset bit in the control register returns the block to its idle state.

Top module: `txq_dual_ctrl`

## Requirements
- R1: The channel-select register (offset 1) keeps a written 0 or 1; any other written value is stored as 0.
- R2: A write to the push register (offset 4) appends four bytes to the selected channel's queue, bits 7:0 first and bits 31:24 last, but only when at least four bytes are free; otherwise the write is dropped and the queue is unchanged. The fill counts read at offsets 9 (channel 0) and 10 (channel 1).
- R3: A write to a length register (offset 2 for channel 0, 3 for channel 1) above the queue depth stores the queue depth.
- R4: Writing bit 0 of a start register (offset 5 for channel 0, 6 for channel 1) has an effect only when control bit 0 (transmit enable) is set. A start on a channel that is already waiting or sending is ignored.
- R5: A started channel sends the smaller of its length and its current fill. When that count is zero, no byte is sent, no status bit is set and the queue is left as it was.
- R6: After the last byte of a frame is accepted, that channel's queue is emptied, its length reads 0, and its status bit (bit 0 for channel 0, bit 1 for channel 1, offset 8) is set.
- R7: Writing the status register clears each status bit written as 1 and leaves the others.
- R8: The interrupt output is high exactly when some status bit and the matching bit of the enable register (offset 7) are both set.
- R9: Writing the control register (offset 0) with bit 7 set does the following. It empties both queues and clears both lengths, the channel select, the enable and status registers, and any waiting or sending frame. It stores the written value with bit 7 cleared.
- R10: While `tx_valid` is high and `tx_ready` is low, data, last and channel tag hold steady. `tx_last` is high only on the frame's final byte.
- R11: Frames from both channels leave on the shared output, each tagged by `tx_chan`. A channel started while the other is sending is sent after it finishes.
- R12: After reset every register reads 0 and `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_waddr | input | 4 | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word offset |
| reg_rdata | output | 32 | Register read data, combinational from the read offset |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_chan | output | 1 | Channel the current byte comes from |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that the queue depth is a power of two no smaller than four. They also assume that after the last release of `rst_n`, the sink does not retract a byte by dropping ready in the middle of a handshake in a way that would reorder data. The bench produces only single-cycle writes to defined offsets, and it drives `tx_ready` as either held low, held high or random per cycle. Every frame it starts comes from a queue that the bench itself filled through the push register. A reference model in the bench tracks both queues as byte lists and predicts every output on every cycle. This includes the clock where a start, a push and a frame's end fall together.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int NCH      = 2;
  localparam int DW       = 32;
  localparam int BW       = 8;
  localparam int RAW      = 4;
  localparam int CTRL_W   = 8;
  localparam int TXEN_BIT = 0;
  localparam int SRST_BIT = 7;

  typedef enum logic [RAW-1:0] {
    OFS_CTRL  = 4'd0,
    OFS_SEL   = 4'd1,
    OFS_LEN0  = 4'd2,
    OFS_LEN1  = 4'd3,
    OFS_PUSH  = 4'd4,
    OFS_GO0   = 4'd5,
    OFS_GO1   = 4'd6,
    OFS_IEN   = 4'd7,
    OFS_ISTS  = 4'd8,
    OFS_FILL0 = 4'd9,
    OFS_FILL1 = 4'd10
  } txq_ofs_e;
endpackage

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [31:0]   wdata,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [LW-1:0] fill
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [LW-1:0] LIM = LW'(DEPTH - 4);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] fill_q, fill_d;
  logic          push_ok;

  assign push_ok = push && !clr && (fill_q <= LIM);

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (clr) begin
      wr_d   = '0;
      rd_d   = '0;
      fill_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + AW'(4);
      if (pop)     rd_d = rd_q + AW'(1);
      fill_d = fill_q + (push_ok ? LW'(4) : '0) - (pop ? LW'(1) : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      for (int k = 0; k < 4; k++) mem[wr_q + AW'(k)] <= wdata[8*k +: 8];
    end
  end

  assign head = mem[rd_q];
  assign fill = fill_q;

  p_fill_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= LW'(DEPTH));
  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && !pop && fill_q > LIM) |=> $stable(fill_q));
  p_push_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && !pop && fill_q <= LIM) |=> fill_q == $past(fill_q) + LW'(4));
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [RAW-1:0]          waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [RAW-1:0]          raddr,
  output logic [DW-1:0]           rdata,
  input  logic [NCH-1:0][LW-1:0]  fill,
  input  logic [NCH-1:0]          done,
  output logic                    srst,
  output logic                    push,
  output logic                    sel,
  output logic [NCH-1:0][LW-1:0]  len,
  output logic [NCH-1:0]          go,
  output logic                    irq
);
  localparam logic [DW-1:0] DEPTH_W = DW'(DEPTH);

  logic [CTRL_W-1:0]      ctrl_q, ctrl_d;
  logic                   sel_q, sel_d;
  logic [NCH-1:0][LW-1:0] len_q, len_d;
  logic [NCH-1:0]         ien_q, ien_d, ists_q, ists_d;
  logic [LW-1:0]          len_wr;

  assign srst   = we && (waddr == OFS_CTRL) && wdata[SRST_BIT];
  assign push   = we && (waddr == OFS_PUSH);
  assign len_wr = (wdata > DEPTH_W) ? LW'(DEPTH) : wdata[LW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_go
    assign go[c] = we && (waddr == RAW'(OFS_GO0 + c)) && wdata[0] && ctrl_q[TXEN_BIT];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    len_d  = len_q;
    ien_d  = ien_q;
    ists_d = ists_q;
    if (srst) begin
      ctrl_d = wdata[CTRL_W-1:0] & ~(CTRL_W'(1) << SRST_BIT);
      sel_d  = 1'b0;
      len_d  = '0;
      ien_d  = '0;
      ists_d = '0;
    end else begin
      if (we) begin
        unique case (waddr)
          OFS_CTRL: ctrl_d = wdata[CTRL_W-1:0];
          OFS_SEL:  sel_d  = (wdata < DW'(NCH)) ? wdata[0] : 1'b0;
          OFS_LEN0: len_d[0] = len_wr;
          OFS_LEN1: len_d[1] = len_wr;
          OFS_IEN:  ien_d  = wdata[NCH-1:0];
          OFS_ISTS: ists_d = ists_q & ~wdata[NCH-1:0];
          default:  ;
        endcase
      end
      for (int c = 0; c < NCH; c++) begin
        if (done[c]) len_d[c] = '0;
      end
      ists_d = ists_d | done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= 1'b0;
      len_q  <= '0;
      ien_q  <= '0;
      ists_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
      len_q  <= len_d;
      ien_q  <= ien_d;
      ists_q <= ists_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (raddr)
      OFS_CTRL:  rdata = DW'(ctrl_q);
      OFS_SEL:   rdata = DW'(sel_q);
      OFS_LEN0:  rdata = DW'(len_q[0]);
      OFS_LEN1:  rdata = DW'(len_q[1]);
      OFS_IEN:   rdata = DW'(ien_q);
      OFS_ISTS:  rdata = DW'(ists_q);
      OFS_FILL0: rdata = DW'(fill[0]);
      OFS_FILL1: rdata = DW'(fill[1]);
      default:   rdata = '0;
    endcase
  end

  assign sel = sel_q;
  assign len = len_q;
  assign irq = |(ists_q & ien_q);

  p_srst_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[SRST_BIT]);
  p_sel_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == OFS_SEL && wdata > DW'(1)) |=> !sel_q);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_len_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      len_q[c] <= LW'(DEPTH));
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == OFS_ISTS && wdata[c] && !done[c]) |=> !ists_q[c]);
    p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && ien_q[c] && !srst && !(we && waddr == OFS_IEN)) |=> irq);
    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && !srst) |=> (ists_q[c] && len_q[c] == '0));
  end
endmodule

// File: rtl/txq_tx_engine.sv
module txq_tx_engine
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   srst,
  input  logic [NCH-1:0]         go,
  input  logic [NCH-1:0][LW-1:0] len,
  input  logic [NCH-1:0][LW-1:0] fill,
  input  logic [NCH-1:0][7:0]    head,
  input  logic                   tx_ready,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  output logic                   tx_chan,
  output logic [NCH-1:0]         pop,
  output logic [NCH-1:0]         done
);
  logic [NCH-1:0] pend_q, pend_d;
  logic           act_q, act_d;
  logic           ach_q, ach_d;
  logic [LW-1:0]  rem_q, rem_d;
  logic           hs, fin, gch;
  logic [LW-1:0]  cnt;

  assign hs  = act_q && tx_ready;
  assign fin = hs && (rem_q == LW'(1));
  assign gch = pend_q[0] ? 1'b0 : 1'b1;
  assign cnt = (len[gch] < fill[gch]) ? len[gch] : fill[gch];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pop[c]  = hs  && (ach_q == 1'(c));
    assign done[c] = fin && (ach_q == 1'(c));
  end

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    ach_d  = ach_q;
    rem_d  = rem_q;
    if (srst) begin
      pend_d = '0;
      act_d  = 1'b0;
      ach_d  = 1'b0;
      rem_d  = '0;
    end else begin
      if (!act_q && (|pend_q)) begin
        pend_d[gch] = 1'b0;
        if (cnt != '0) begin
          act_d = 1'b1;
          ach_d = gch;
          rem_d = cnt;
        end
      end
      if (hs) rem_d = rem_q - LW'(1);
      if (fin) act_d = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (go[c] && !(pend_q[c] || (act_q && ach_q == 1'(c)))) pend_d[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= 1'b0;
      ach_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      ach_q  <= ach_d;
      rem_q  <= rem_d;
    end
  end

  assign tx_valid = act_q;
  assign tx_data  = head[ach_q];
  assign tx_last  = act_q && (rem_q == LW'(1));
  assign tx_chan  = ach_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !srst) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_chan)));
  p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !(tx_valid && tx_chan == $past(tx_chan)
                                           && !$past(|pend_q)));
  p_zero_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (|pend_q) && cnt == '0 && !srst) |=> !tx_valid);
  p_done_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  p_srst_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!tx_valid && pend_q == '0));
endmodule

// File: rtl/txq_dual_ctrl.sv
module txq_dual_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [3:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_chan,
  output logic        irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [1:0]             rs_q;
  logic                   core_rst_n;
  logic                   srst, push, sel;
  logic [NCH-1:0]         go, pop, done;
  logic [NCH-1:0][LW-1:0] len, fill;
  logic [NCH-1:0][7:0]    head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  txq_regs #(.DEPTH(DEPTH), .LW(LW)) u_regs (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (reg_we),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .raddr (reg_raddr),
    .rdata (reg_rdata),
    .fill  (fill),
    .done  (done),
    .srst  (srst),
    .push  (push),
    .sel   (sel),
    .len   (len),
    .go    (go),
    .irq   (irq)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_fifo
    txq_byte_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
      .clk   (clk),
      .rst_n (core_rst_n),
      .clr   (srst | done[c]),
      .push  (push && (sel == 1'(c))),
      .wdata (reg_wdata),
      .pop   (pop[c]),
      .head  (head[c]),
      .fill  (fill[c])
    );
  end

  txq_tx_engine #(.DEPTH(DEPTH), .LW(LW)) u_eng (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .srst     (srst),
    .go       (go),
    .len      (len),
    .fill     (fill),
    .head     (head),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .tx_chan  (tx_chan),
    .pop      (pop),
    .done     (done)
  );
endmodule

// File: tb/txq_dual_ctrl_bench.sv
module txq_dual_ctrl_bench;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic [31:0] rdata;
  logic        tx_valid, tx_last, tx_chan, irq;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int n_chk = 0, n_fail = 0, n_hs = 0;
  int rdy_mode = 0;
  bit run = 1'b0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  txq_dual_ctrl #(.DEPTH(DEPTH)) u_txq_dual_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_chan(tx_chan), .irq(irq)
  );

  // reference model state
  byte unsigned mq [2][$];
  int  mlen [2];
  int  msel, mctrl, mien, mists, mach, mrem;
  bit  mpend [2];
  bit  mact;
  bit [1:0] mrs;

  function automatic void mreset();
    mq[0].delete(); mq[1].delete();
    mlen[0] = 0; mlen[1] = 0;
    msel = 0; mctrl = 0; mien = 0; mists = 0; mach = 0; mrem = 0;
    mpend[0] = 0; mpend[1] = 0; mact = 0;
  endfunction

  function automatic void mstep();
    bit hs, fin;
    int fpre [2];
    int lpre [2];
    bit ppre [2];
    bit apre;
    int chpre, cpre, g, cnt, c;
    int done;
    hs  = mact && tx_ready;
    fin = hs && (mrem == 1);
    if (we && waddr == 4'd0 && wdata[7]) begin
      mreset();
      mctrl = int'(wdata[7:0]) & 8'h7f;
      return;
    end
    for (int k = 0; k < 2; k++) begin
      fpre[k] = mq[k].size(); lpre[k] = mlen[k]; ppre[k] = mpend[k];
    end
    apre = mact; chpre = mach; cpre = mctrl; done = 0;
    if (hs) begin void'(mq[mach].pop_front()); mrem--; end
    if (we && waddr == 4'd4) begin
      c = msel;
      if (!(fin && mach == c) && (DEPTH - fpre[c] >= 4))
        for (int k = 0; k < 4; k++) mq[c].push_back(wdata[8*k +: 8]);
    end
    if (we && (waddr == 4'd2 || waddr == 4'd3))
      mlen[waddr - 4'd2] = (wdata > DEPTH) ? DEPTH : int'(wdata);
    if (fin) begin
      mq[mach].delete(); mlen[mach] = 0; done = 1 << mach; mact = 0;
    end
    if (!apre && (ppre[0] || ppre[1])) begin
      g = ppre[0] ? 0 : 1;
      mpend[g] = 0;
      cnt = (lpre[g] < fpre[g]) ? lpre[g] : fpre[g];
      if (cnt > 0) begin mact = 1; mach = g; mrem = cnt; end
    end
    for (int k = 0; k < 2; k++)
      if (we && waddr == 4'(5 + k) && wdata[0] && cpre[0] &&
          !(ppre[k] || (apre && chpre == k))) mpend[k] = 1;
    if (we && waddr == 4'd0) mctrl = int'(wdata[7:0]);
    if (we && waddr == 4'd1) msel = (wdata < 2) ? int'(wdata) : 0;
    if (we && waddr == 4'd7) mien = int'(wdata[1:0]);
    if (we && waddr == 4'd8) mists = mists & ~int'(wdata[1:0]);
    mists = mists | done;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs = 2'b00;
      mreset();
    end else begin
      if (mrs[1]) mstep(); else mreset();
      mrs = {mrs[0], 1'b1};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("R10 tx_valid", 32'(tx_valid), 32'(mact));
      if (mact) begin
        chk("R2 tx_data", 32'(tx_data), 32'(mq[mach][0]));
        chk("R10 tx_last", 32'(tx_last), 32'(mrem == 1));
        chk("R11 tx_chan", 32'(tx_chan), 32'(mach));
      end
      chk("R8 irq", 32'(irq), 32'((mists & mien) != 0));
      if (tx_valid && tx_ready) n_hs++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      case (rdy_mode)
        0: tx_ready = 1'b0;
        1: tx_ready = 1'b1;
        default: tx_ready = 1'($urandom % 2);
      endcase
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic rchk(input logic [3:0] a, input logic [31:0] e, input string tag);
    raddr = a; #1;
    chk(tag, rdata, e);
    @(posedge clk); #2;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!mact && !mpend[0] && !mpend[1]) break;
      @(posedge clk); #2;
    end
    idle(2);
  endtask

  function automatic logic [31:0] mkw(input logic [7:0] b);
    return {b + 8'd3, b + 8'd2, b + 8'd1, b};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int h0;
    idle(3);
    rst_n = 1'b1;
    run = 1'b1;
    idle(3);
    // R12 reset state
    rchk(4'd0, 0, "R12 ctrl");
    rchk(4'd1, 0, "R12 sel");
    rchk(4'd9, 0, "R12 fill0");
    rchk(4'd8, 0, "R12 status");
    chk("R12 tx_valid", 32'(tx_valid), 0);
    chk("R12 irq", 32'(irq), 0);
    // R1 select
    wr(4'd1, 5);          rchk(4'd1, 0, "R1 sel out of range");
    wr(4'd1, 1);          rchk(4'd1, 1, "R1 sel one");
    wr(4'd1, 0);          rchk(4'd1, 0, "R1 sel zero");
    // R3 clamp
    wr(4'd2, 1000);       rchk(4'd2, 64, "R3 clamp");
    wr(4'd2, 64);         rchk(4'd2, 64, "R3 exact depth");
    wr(4'd2, 10);         rchk(4'd2, 10, "R3 small");
    // R2 push
    wr(4'd4, mkw(8'h10)); wr(4'd4, mkw(8'h20)); wr(4'd4, mkw(8'h30));
    rchk(4'd9, 12, "R2 fill0 after pushes");
    rchk(4'd10, 0, "R2 fill1 untouched");
    // R4 start without enable
    wr(4'd5, 1); idle(5);
    chk("R4 no send when disabled", 32'(tx_valid), 0);
    rchk(4'd9, 12, "R4 fill kept");
    rchk(4'd8, 0, "R4 no status");
    // send ten bytes with random ready, repeated start ignored
    wr(4'd7, 3); wr(4'd0, 1);
    rdy_mode = 2; h0 = n_hs;
    wr(4'd5, 1); wr(4'd5, 1);
    wait_idle();
    chk("R5 bytes sent min(len,fill)", 32'(n_hs - h0), 10);
    rchk(4'd9, 0, "R6 fill0 flushed");
    rchk(4'd2, 0, "R6 len0 cleared");
    rchk(4'd8, 1, "R6 status bit0");
    chk("R8 irq high", 32'(irq), 1);
    // R7 write one to clear
    wr(4'd8, 2);          rchk(4'd8, 1, "R7 other bit kept");
    wr(4'd8, 1);          rchk(4'd8, 0, "R7 cleared");
    chk("R8 irq low", 32'(irq), 0);
    // R5 zero length
    wr(4'd4, mkw(8'h40)); wr(4'd4, mkw(8'h44));
    h0 = n_hs;
    wr(4'd5, 1); idle(5);
    chk("R5 zero count sends nothing", 32'(n_hs - h0), 0);
    rchk(4'd8, 0, "R5 zero count no status");
    rchk(4'd9, 8, "R5 zero count keeps queue");
    // R5 length above fill
    wr(4'd2, 100); h0 = n_hs;
    wr(4'd5, 1); wait_idle();
    chk("R5 sends fill when len larger", 32'(n_hs - h0), 8);
    wr(4'd8, 3);
    // R11 second channel waits
    wr(4'd1, 1); wr(4'd4, mkw(8'h50)); wr(4'd4, mkw(8'h58)); wr(4'd3, 6);
    wr(4'd1, 0); wr(4'd4, mkw(8'h60)); wr(4'd2, 4);
    rdy_mode = 0; h0 = n_hs;
    wr(4'd6, 1); idle(3);
    chk("R11 ch1 first", 32'(tx_chan), 1);
    wr(4'd5, 1); wr(4'd6, 1); idle(3);
    rdy_mode = 2; wait_idle();
    chk("R11 both frames", 32'(n_hs - h0), 10);
    rchk(4'd8, 3, "R11 both status");
    rchk(4'd10, 0, "R6 fill1 flushed");
    // R9 soft reset mid frame
    wr(4'd4, mkw(8'h70)); wr(4'd4, mkw(8'h74)); wr(4'd2, 8);
    rdy_mode = 0; wr(4'd5, 1); idle(3);
    chk("R9 frame active", 32'(tx_valid), 1);
    wr(4'd0, 32'h81);
    chk("R9 output idle", 32'(tx_valid), 0);
    rchk(4'd0, 1, "R9 ctrl bit7 dropped");
    rchk(4'd2, 0, "R9 len0");
    rchk(4'd9, 0, "R9 fill0");
    rchk(4'd7, 0, "R9 enable");
    rchk(4'd8, 0, "R9 status");
    // R2 full queue drop
    wr(4'd1, 1);
    for (int i = 0; i < 16; i++) wr(4'd4, mkw(8'(4 * i)));
    rchk(4'd10, 64, "R2 full");
    wr(4'd4, 32'hdeadbeef);
    rchk(4'd10, 64, "R2 dropped when full");
    wr(4'd3, 64); rdy_mode = 2; h0 = n_hs;
    wr(4'd6, 1); wait_idle();
    chk("R2 full frame length", 32'(n_hs - h0), 64);
    rchk(4'd10, 0, "R6 fill1 after full frame");
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule